// File: doc/BRIEF.md
# Per-Channel Exposure Gate Controller

This block drives the three overflow-drain gate levels of a three-colour line sensor, one each for red, green and blue. When a gate is high, that channel's photocharge is drained away. When the gate drops, integration begins. Every channel therefore integrates from its own gate falling edge to the end of the line, and each colour can be balanced separately.

A line sequencer supplies two pulses. `xfer_end` is a one-cycle pulse that marks the falling edge of the inner transfer gate, which is the end of one line and the start of the next. `pix_tick` is a one-cycle pulse on each shift-register clock edge. At `xfer_end` the block samples each channel's enable and exposure request (16-bit, in pixel elements) and works out where that channel's gate must fall. The gate rises together with the transfer edge. It then falls on the pixel boundary that leaves the requested exposure before the next transfer edge. Requests that cannot be met are adjusted:

- A request too long for the line becomes full-line integration, with no pulse at all.
- A request too short is raised to the shortest legal exposure.
- A fall that would come too early is held back until the minimum gate-high time has passed.

Top module: `exp_gate_ctrl`

## Requirements
- R1: The three channels are fully independent. Each channel's `gate` bit (bit 0 red, bit 1 green, bit 2 blue) follows only that channel's `chan_en` and `exp_len` bits.
- R2: For a channel in pulse mode, the gate goes high on the clock edge that samples `xfer_end`. A gate never rises at any other edge.
- R3: The gate falls on the `pix_tick` edge at which the count of ticks since `xfer_end` reaches LINE_PIX minus the exposure. This leaves the exposure in pixel elements before the next `xfer_end` when lines are LINE_PIX ticks long. A gate only ever falls on a `pix_tick` edge.
- R4: A channel whose `chan_en` bit is 0 when `xfer_end` is sampled keeps its gate low for the whole of that line.
- R5: An exposure of LINE_PIX − XFER_PIX or more is full-line integration, and the gate stays low for the whole line.
- R6: An exposure below MIN_EXP_PIX = ceil(MIN_CLKS / PIX_CLKS) is raised to MIN_EXP_PIX, where MIN_CLKS = ceil(CLK_MHZ · MIN_NS / 1000). This keeps the gate-clear time at the end of the line at least MIN_NS.
- R7: A gate stays high for at least MIN_CLKS clocks. If the computed fall comes sooner, it moves to the first `pix_tick` edge at which the minimum is met.
- R8: `chan_en` and `exp_len` are sampled only at `xfer_end`. Changing them in the middle of a line does not alter that line's gates.
- R9: `exp_active` goes high on the edge where any gate falls and stays high until the edge that samples the next `xfer_end`, which clears it.
- R10: Under synchronous active-low reset, all gates and `exp_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_end | input | 1 | One-cycle pulse at the inner transfer gate falling edge (line boundary) |
| pix_tick | input | 1 | One-cycle pulse on each shift-register clock edge |
| chan_en | input | NUM_CH | Per-channel exposure-control enable |
| exp_len | input | NUM_CH×EXP_W | Per-channel exposure in pixel elements |
| gate | output | NUM_CH | Overflow-drain gate level per channel |
| exp_active | output | 1 | A channel has started integrating in this line |

## Verification
The lines are driven with three distinct mid-range exposures, which separates the channels and confirms the backward-from-line-end placement. Zero and tiny exposures exercise the raise to the minimum clear time. Exposures just below the full-line limit exercise the held-back fall for minimum high time. The maximum and other over-long values fall into full-line integration. Disabled channels are mixed with active ones, and the inputs for each next line are changed halfway through the current line, so a design that samples the settings at any point other than the line boundary produces wrong gate widths. The `exp_active` width is checked against the earliest falling channel in each line.

// File: rtl/expgate_pkg.sv
// Shared constants and helpers for the exposure gate controller.
package expgate_pkg;
    localparam int NUM_CH = 3;

    // Integer ceiling division used for derived timing limits.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction
endpackage

// File: rtl/exp_line_timer.sv
// Counts pixel ticks since the last line boundary.
// Assumes xfer_end and pix_tick are single-cycle pulses; the count saturates at LINE_PIX.
module exp_line_timer #(
    parameter int LINE_PIX = 2128,
    localparam int CW = $clog2(LINE_PIX + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xfer_end,
    input  logic        pix_tick,
    output logic [CW:0] pix_next
);
    logic [CW-1:0] cnt;

    // Tick counter, restarted at each line boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || xfer_end)
            cnt <= '0;
        else if (pix_tick && cnt != CW'(LINE_PIX))
            cnt <= cnt + 1'b1;
    end

    // Count value that the next tick will produce.
    assign pix_next = {1'b0, cnt} + 1'b1;
endmodule

// File: rtl/exp_planner.sv
// Turns one channel's enable and exposure request into a pulse decision and a fall position.
// Purely combinational; its outputs are only used in the cycle that samples xfer_end.
module exp_planner #(
    parameter int EXP_W    = 16,
    parameter int LINE_PIX = 2128,
    parameter int XFER_PIX = 4,
    parameter int MIN_EXP  = 10,
    localparam int CW = $clog2(LINE_PIX + 1)
) (
    input  logic             en,
    input  logic [EXP_W-1:0] exp_len,
    output logic             pulse,
    output logic [CW-1:0]    fall_pos
);
    localparam int FULL_LIM = LINE_PIX - XFER_PIX;

    logic [31:0] req;
    logic [31:0] eff;

    // Clamp the request: full line means no pulse, short requests are raised.
    always_comb begin
        req      = 32'(exp_len);
        pulse    = en && (req < 32'(FULL_LIM));
        eff      = (req < 32'(MIN_EXP)) ? 32'(MIN_EXP) : req;
        fall_pos = CW'(32'(LINE_PIX) - eff);
    end
endmodule

// File: rtl/exp_gate_channel.sv
// Drives one overflow-drain gate: raise at the line boundary, drop on a pixel tick.
// Assumes fall_in/pulse_in are valid in the cycle xfer_end is high.
module exp_gate_channel #(
    parameter int LINE_PIX = 2128,
    parameter int MIN_CLKS = 200,
    localparam int CW = $clog2(LINE_PIX + 1),
    localparam int HW = $clog2(MIN_CLKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_end,
    input  logic          pix_tick,
    input  logic [CW:0]   pix_next,
    input  logic          pulse_in,
    input  logic [CW-1:0] fall_in,
    output logic          gate,
    output logic          fall_now
);
    logic [CW-1:0] fall_q;
    logic [HW-1:0] hi_cnt;
    logic          hi_ok;

    // Minimum-high satisfied once this edge would complete MIN_CLKS high cycles.
    assign hi_ok    = hi_cnt >= HW'(MIN_CLKS - 1);
    // Drop condition: on a tick, at or past the planned position, min-high met.
    assign fall_now = gate && pix_tick && !xfer_end && hi_ok &&
                      (pix_next >= {1'b0, fall_q});

    // Gate level, planned fall position and saturating high-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate   <= 1'b0;
            fall_q <= '0;
            hi_cnt <= '0;
        end else if (xfer_end) begin
            gate   <= pulse_in;
            fall_q <= fall_in;
            hi_cnt <= '0;
        end else begin
            if (gate && hi_cnt != HW'(MIN_CLKS))
                hi_cnt <= hi_cnt + 1'b1;
            if (fall_now)
                gate <= 1'b0;
        end
    end
endmodule

// File: rtl/exp_gate_ctrl.sv
// Three-channel overflow-gate exposure controller for a three-colour line sensor.
// Assumes xfer_end marks the inner transfer gate falling edge and pix_tick the shift clock edges.
module exp_gate_ctrl #(
    parameter int NUM_CH   = expgate_pkg::NUM_CH,
    parameter int EXP_W    = 16,
    parameter int LINE_PIX = 2128,
    parameter int XFER_PIX = 4,
    parameter int PIX_CLKS = 20,
    parameter int CLK_MHZ  = 200,
    parameter int MIN_NS   = 1000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        xfer_end,
    input  logic                        pix_tick,
    input  logic [NUM_CH-1:0]           chan_en,
    input  logic [NUM_CH-1:0][EXP_W-1:0] exp_len,
    output logic [NUM_CH-1:0]           gate,
    output logic                        exp_active
);
    localparam int MIN_CLKS = expgate_pkg::ceil_div(CLK_MHZ * MIN_NS, 1000);
    localparam int MIN_EXP  = expgate_pkg::ceil_div(MIN_CLKS, PIX_CLKS);
    localparam int CW       = $clog2(LINE_PIX + 1);

    logic [CW:0]       pix_next;
    logic [NUM_CH-1:0] fall_now;

    exp_line_timer #(.LINE_PIX(LINE_PIX)) u_timer (
        .clk(clk), .rst_n(rst_n), .xfer_end(xfer_end),
        .pix_tick(pix_tick), .pix_next(pix_next)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic          pulse;
        logic [CW-1:0] fall_pos;

        exp_planner #(
            .EXP_W(EXP_W), .LINE_PIX(LINE_PIX),
            .XFER_PIX(XFER_PIX), .MIN_EXP(MIN_EXP)
        ) u_plan (
            .en(chan_en[c]), .exp_len(exp_len[c]),
            .pulse(pulse), .fall_pos(fall_pos)
        );

        exp_gate_channel #(.LINE_PIX(LINE_PIX), .MIN_CLKS(MIN_CLKS)) u_gate (
            .clk(clk), .rst_n(rst_n), .xfer_end(xfer_end), .pix_tick(pix_tick),
            .pix_next(pix_next), .pulse_in(pulse), .fall_in(fall_pos),
            .gate(gate[c]), .fall_now(fall_now[c])
        );
    end

    // Integration-started flag: set by any gate drop, cleared at the line boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || xfer_end)
            exp_active <= 1'b0;
        else if (|fall_now)
            exp_active <= 1'b1;
    end
endmodule

// File: rtl/exp_gate_ctrl_chk.sv
// Protocol checker for exp_gate_ctrl, attached with bind.
module exp_gate_ctrl_chk #(
    parameter int NUM_CH   = 3,
    parameter int MIN_CLKS = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_end,
    input logic              pix_tick,
    input logic [NUM_CH-1:0] chan_en,
    input logic [NUM_CH-1:0] gate,
    input logic              exp_active
);
    localparam int HW = $clog2(MIN_CLKS + 2);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        logic [HW-1:0] high_len;

        // Count how many cycles the gate has been high, saturating.
        always_ff @(posedge clk) begin
            if (!rst_n || !gate[c])
                high_len <= '0;
            else if (high_len != HW'(MIN_CLKS + 1))
                high_len <= high_len + 1'b1;
        end

        AST_RISE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate[c]) |-> $past(xfer_end)); // R2
        AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gate[c]) |-> $past(pix_tick)); // R3
        AST_OFF_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_end && !chan_en[c]) |=> !gate[c]); // R4
        AST_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gate[c]) |-> (high_len >= HW'(MIN_CLKS))); // R7
    end

    AST_ACTIVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end |=> !exp_active); // R9
    AST_ACTIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(exp_active)) |-> ($countones($past(gate) & ~gate) != 0)); // R9
endmodule

bind exp_gate_ctrl exp_gate_ctrl_chk #(.NUM_CH(NUM_CH), .MIN_CLKS(MIN_CLKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_end(xfer_end), .pix_tick(pix_tick),
    .chan_en(chan_en), .gate(gate), .exp_active(exp_active)
);

// File: tb/exp_gate_ctrl_tb.sv
// Scoreboard bench: the line driver pushes expected per-line widths, the monitor measures and compares.
module exp_gate_ctrl_tb;
    localparam int NCH = 3, LINE = 64, XFER = 2, PCLK = 4, MINC = 20, MINE = 5, NL = 6;

    logic clk = 1'b0, rst_n = 1'b0, xfer_end = 1'b0, pix_tick = 1'b0;
    logic [NCH-1:0] chan_en = '0;
    logic [NCH-1:0][15:0] exp_len = '0;
    logic [NCH-1:0] gate;
    logic exp_active;

    int vectors = 0, fails = 0;
    int expq[$];
    int exps[NL+1][NCH];
    bit ens[NL+1][NCH];
    bit done = 0;

    always #2.5 clk = ~clk;

    exp_gate_ctrl #(.LINE_PIX(LINE), .XFER_PIX(XFER), .PIX_CLKS(PCLK),
                    .CLK_MHZ(200), .MIN_NS(100)) u_dut (
        .clk(clk), .rst_n(rst_n), .xfer_end(xfer_end), .pix_tick(pix_tick),
        .chan_en(chan_en), .exp_len(exp_len), .gate(gate), .exp_active(exp_active));

    // Expected high cycles of one gate from the requirements (R3..R7).
    function automatic int exp_high(bit en, int e);
        int fp;
        if (!en || e >= LINE - XFER) return 0;      // R4, R5
        if (e < MINE) e = MINE;                     // R6
        fp = LINE - e;
        if (fp * PCLK < MINC) fp = (MINC + PCLK - 1) / PCLK; // R7
        return fp * PCLK;
    endfunction

    task automatic check(string req, int act, int expv);
        vectors++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic apply(int i);
        for (int c = 0; c < NCH; c++) begin
            chan_en[c] = ens[i][c];
            exp_len[c] = 16'(exps[i][c]);
        end
    endtask

    // One line: boundary pulse, ticks every PCLK cycles, next settings mid-line (R8).
    task automatic run_line(int i, bit push);
        int mn;
        for (int cyc = 0; cyc < LINE * PCLK; cyc++) begin
            @(posedge clk); #1;
            xfer_end = (cyc == 0);
            pix_tick = (cyc % PCLK == 0);
            if (cyc == 0 && push) begin
                mn = 0;
                for (int c = 0; c < NCH; c++) begin
                    int h = exp_high(ens[i][c], exps[i][c]);
                    expq.push_back(h);
                    if (h != 0 && (mn == 0 || h < mn)) mn = h;
                end
                expq.push_back(mn == 0 ? 0 : LINE * PCLK - mn); // R9
            end
            if (cyc == LINE * PCLK / 2) apply(i + 1);
            if (!push) break;
        end
    endtask

    // Monitor: counts high samples per line and compares at each boundary.
    int hi_cnt[NCH];
    int act_cnt = 0;
    bit started = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) hi_cnt[c] += gate[c];
            act_cnt += exp_active;
            if (xfer_end) begin
                if (started) begin
                    for (int c = 0; c < NCH; c++)
                        check($sformatf("R1/R3 gate%0d width", c), hi_cnt[c], expq.pop_front());
                    check("R9 exp_active width", act_cnt, expq.pop_front());
                end
                started = 1;
                for (int c = 0; c < NCH; c++) hi_cnt[c] = 0;
                act_cnt = 0;
            end
        end
    end

    initial begin
        exps[0] = '{10, 30, 50};       ens[0] = '{1, 1, 1}; // R1 R3 distinct channels
        exps[1] = '{0, 20, 62};        ens[1] = '{1, 0, 1}; // R6 floor, R4 off, R5 full
        exps[2] = '{61, 60, 59};       ens[2] = '{1, 1, 1}; // R7 held-back fall
        exps[3] = '{10, 10, 10};       ens[3] = '{0, 0, 0}; // R4 all disabled
        exps[4] = '{65535, 1, 5};      ens[4] = '{1, 1, 1}; // R5 max, R6 floor edge
        exps[5] = '{20, 20, 20};       ens[5] = '{1, 1, 1}; // R8 settings change mid-line
        exps[6] = '{0, 0, 0};          ens[6] = '{0, 0, 0};
        apply(0);
        repeat (4) @(posedge clk);
        #1;
        @(negedge clk);
        check("R10 gate in reset", int'(gate), 0);
        check("R10 exp_active in reset", int'(exp_active), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        for (int i = 0; i < NL; i++) run_line(i, 1'b1);
        run_line(NL, 1'b0);
        @(posedge clk); #1 xfer_end = 1'b0; pix_tick = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule